// File: doc/BRIEF.md
# Multistandard Raster Timing Generator

This block is a free-running raster timing master. It counts pixels and lines for four video formats: two frame rates (60 Hz and 50 Hz), each at either the 13.5 MHz component sampling rate or the square-pixel rate. Its pixel counter advances only on cycles where `pix_en` is high, so one clock can carry any of the four pixel rates. It needs no incoming video. It produces complete line, field and frame timing by itself, so it can serve as the reference for other video engines in the system.

From the counters it derives the following outputs:
- a line strobe and a field strobe;
- a field identifier;
- horizontal and vertical active-area flags;
- two horizontal sync outputs.

Each sync output has a rising and a falling position. Each position is a per-format default plus a programmed offset, and the sum wraps at the current line length. A single output-enable flag tells the pad ring whether the timing pins drive or float. At reset this flag is loaded from a strap input. After reset only a register write changes it.

Top module: `video_timing_gen`

## Requirements
- R1: `fmt_sel` encodes the format as 0 = 60 Hz component, 1 = 50 Hz component, 2 = 60 Hz square, 3 = 50 Hz square. The line length is 858, 864, 780 or 944 enabled pixel cycles, in that order.
- R2: `h_active` is high for exactly 720, 720, 640 or 768 pixel positions of each line (formats 0 to 3). The window starts at pixel position (line length − active width − 16).
- R3: A frame has `F60_LINES` lines (60 Hz formats) or `F50_LINES` lines (50 Hz formats), with defaults 525 and 625. Field 0 covers the first ceil(F/2) lines and field 1 covers the rest. `field_id` reads 0 in field 0 and 1 in field 1. `field_sol` coincides with `line_sol` on the first line of each field.
- R4: In each field, `v_active` is high for VACT/2 consecutive lines. They start at field-relative line VBL. The defaults are VACT = 480 and VBL = 20 for 60 Hz, and VACT = 580 and VBL = 22 for 50 Hz.
- R5: Each sync output is high from its begin position up to, but not including, its end position. Each position is (default + offset) mod line length, with offsets below 1024. The defaults are: output 1 begins at 0, output 2 begins at 32, and each ends 64 pixels (component formats) or 58 pixels (square formats) after its begin.
- R6: When the wrapped begin position lies after the wrapped end position, the sync pulse spans the end of the line. It stays high from the begin position through the last pixel, and from pixel 0 up to the end position.
- R7: The two sync outputs are independent. Offsets programmed for one output do not move the edges of the other.
- R8: A new `fmt_sel` value takes effect only at the first pixel of the next frame. The line in progress and the rest of the frame keep the old format.
- R9: `line_sol` is high for one enabled cycle at pixel position 0 of every line.
- R10: While `pix_en` is low, the counters hold. `line_sol` stays low, and the active flags and the field identifier do not change.
- R11: `tmg_oe` takes the inverse of `hiz_strap` while reset is held. After reset it changes only on `oe_wr`, when it takes `oe_wdata` one cycle later. A strap change after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable; counters advance when high |
| fmt_sel | input | 2 | Format select, applied at the next frame start |
| hs1_beg_ofs | input | OFS_W | Offset added to the default begin position of sync output 1 |
| hs1_end_ofs | input | OFS_W | Offset added to the default end position of sync output 1 |
| hs2_beg_ofs | input | OFS_W | Offset added to the default begin position of sync output 2 |
| hs2_end_ofs | input | OFS_W | Offset added to the default end position of sync output 2 |
| oe_wr | input | 1 | Write strobe for the output-enable flag |
| oe_wdata | input | 1 | Value written to the output-enable flag |
| hiz_strap | input | 1 | Strap sampled during reset; 1 = timing pins float after reset |
| hs1 | output | 1 | Horizontal sync output 1 |
| hs2 | output | 1 | Horizontal sync output 2 |
| line_sol | output | 1 | Line start strobe |
| field_sol | output | 1 | Field start strobe |
| field_id | output | 1 | Field identifier |
| h_active | output | 1 | Horizontal active-area flag |
| v_active | output | 1 | Vertical active-area flag |
| tmg_oe | output | 1 | Drive enable for all timing pins |

## Verification
The hardest condition to reach from the ports is a frame boundary, together with the format switch that happens there. At the default line counts, a frame runs to hundreds of thousands of cycles. The bench therefore builds the block with small line-count parameters. It changes `fmt_sel` in the middle of a frame, shows that the next line keeps the old length, and then waits for a `field_sol` with `field_id` low before measuring the new length. The wrapped sync case is set up by choosing offsets whose sums pass the line length. The bench then reconstructs each edge from one full line of samples, so that an edge sitting at pixel 0 is still seen.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int PIX_W = 10;
  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic [1:0] {
    FMT_60_CMP = 2'd0,
    FMT_50_CMP = 2'd1,
    FMT_60_SQ  = 2'd2,
    FMT_50_SQ  = 2'd3
  } vfmt_e;

  localparam pix_t HS_GAP_FRONT = 10'd16;
  localparam pix_t HS_WID_CMP   = 10'd64;
  localparam pix_t HS_WID_SQ    = 10'd58;
  localparam pix_t HS2_BASE     = 10'd32;

  function automatic pix_t line_len(vfmt_e f);
    case (f)
      FMT_60_CMP: return 10'd858;
      FMT_50_CMP: return 10'd864;
      FMT_60_SQ:  return 10'd780;
      default:    return 10'd944;
    endcase
  endfunction

  function automatic pix_t act_px(vfmt_e f);
    case (f)
      FMT_60_SQ: return 10'd640;
      FMT_50_SQ: return 10'd768;
      default:   return 10'd720;
    endcase
  endfunction

  function automatic pix_t act_start(vfmt_e f);
    return line_len(f) - act_px(f) - HS_GAP_FRONT;
  endfunction

  // default sync edge: output index, format, which edge
  function automatic pix_t hs_dflt(int idx, vfmt_e f, logic end_edge);
    pix_t base;
    pix_t wid;
    base = (idx == 0) ? 10'd0 : HS2_BASE;
    wid  = f[1] ? HS_WID_SQ : HS_WID_CMP;
    return end_edge ? base + wid : base;
  endfunction

endpackage

// File: rtl/vtg_raster.sv
module vtg_raster
  import vtg_pkg::*;
#(
  parameter int F60_LINES = 525,
  parameter int F50_LINES = 625,
  parameter int VACT60    = 480,
  parameter int VACT50    = 580,
  parameter int VBL60     = 20,
  parameter int VBL50     = 22,
  parameter int LINE_W    = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pix_en,
  input  vfmt_e fmt_sel,
  output vfmt_e cur_fmt,
  output pix_t  pix,
  output logic  line_sol,
  output logic  field_sol,
  output logic  field_id,
  output logic  h_active,
  output logic  v_active
);

  typedef logic [LINE_W-1:0] ln_t;

  localparam ln_t FL60 = LINE_W'(F60_LINES);
  localparam ln_t FL50 = LINE_W'(F50_LINES);
  localparam ln_t HF60 = LINE_W'((F60_LINES + 1) / 2);
  localparam ln_t HF50 = LINE_W'((F50_LINES + 1) / 2);
  localparam ln_t VA60 = LINE_W'(VACT60 / 2);
  localparam ln_t VA50 = LINE_W'(VACT50 / 2);
  localparam ln_t VB60 = LINE_W'(VBL60);
  localparam ln_t VB50 = LINE_W'(VBL50);

  ln_t  line;
  ln_t  frame_len, half, vbl, vact_f, lf;
  pix_t llen, hst, hend;
  logic eol, eof;

  always_comb begin
    frame_len = cur_fmt[0] ? FL50 : FL60;
    half      = cur_fmt[0] ? HF50 : HF60;
    vbl       = cur_fmt[0] ? VB50 : VB60;
    vact_f    = cur_fmt[0] ? VA50 : VA60;
    llen      = line_len(cur_fmt);
    hst       = act_start(cur_fmt);
    hend      = hst + act_px(cur_fmt);
  end

  assign eol = (pix == llen - 10'd1);
  assign eof = eol && (line == frame_len - ln_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix     <= '0;
      line    <= '0;
      cur_fmt <= fmt_sel;
    end else if (pix_en) begin
      pix <= eol ? '0 : pix + 10'd1;
      if (eol) line <= eof ? '0 : line + ln_t'(1);
      if (eof) cur_fmt <= fmt_sel;
    end
  end

  assign field_id  = (line >= half);
  assign lf        = field_id ? line - half : line;
  assign v_active  = (lf >= vbl) && (lf < vbl + vact_f);
  assign h_active  = (pix >= hst) && (pix < hend);
  assign line_sol  = pix_en && (pix == '0);
  assign field_sol = line_sol && ((line == '0) || (line == half));

endmodule

// File: rtl/vtg_hsync.sv
module vtg_hsync
  import vtg_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int OFS_W = 10
) (
  input  vfmt_e            fmt,
  input  pix_t             pix,
  input  logic [OFS_W-1:0] beg_ofs,
  input  logic [OFS_W-1:0] end_ofs,
  output logic             hs
);

  localparam int SW = ((OFS_W > PIX_W) ? OFS_W : PIX_W) + 1;

  function automatic pix_t place(pix_t dflt, logic [OFS_W-1:0] ofs, pix_t l);
    logic [SW-1:0] s;
    s = SW'(dflt) + SW'(ofs);
    if (s >= SW'(l)) s = s - SW'(l);
    return pix_t'(s);
  endfunction

  pix_t len, b, e;

  always_comb begin
    len = line_len(fmt);
    b   = place(hs_dflt(IDX, fmt, 1'b0), beg_ofs, len);
    e   = place(hs_dflt(IDX, fmt, 1'b1), end_ofs, len);
    if (b <= e) hs = (pix >= b) && (pix < e);
    else        hs = (pix >= b) || (pix < e);
  end

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int F60_LINES = 525,
  parameter int F50_LINES = 625,
  parameter int VACT60    = 480,
  parameter int VACT50    = 580,
  parameter int VBL60     = 20,
  parameter int VBL50     = 22,
  parameter int OFS_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [1:0]       fmt_sel,
  input  logic [OFS_W-1:0] hs1_beg_ofs,
  input  logic [OFS_W-1:0] hs1_end_ofs,
  input  logic [OFS_W-1:0] hs2_beg_ofs,
  input  logic [OFS_W-1:0] hs2_end_ofs,
  input  logic             oe_wr,
  input  logic             oe_wdata,
  input  logic             hiz_strap,
  output logic             hs1,
  output logic             hs2,
  output logic             line_sol,
  output logic             field_sol,
  output logic             field_id,
  output logic             h_active,
  output logic             v_active,
  output logic             tmg_oe
);

  localparam int MAXL   = (F50_LINES > F60_LINES) ? F50_LINES : F60_LINES;
  localparam int LINE_W = $clog2(MAXL) + 1;
  localparam int NHS    = 2;

  vfmt_e cur_fmt;
  pix_t  pix;

  vtg_raster #(
    .F60_LINES(F60_LINES), .F50_LINES(F50_LINES),
    .VACT60(VACT60), .VACT50(VACT50),
    .VBL60(VBL60), .VBL50(VBL50), .LINE_W(LINE_W)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .fmt_sel(vfmt_e'(fmt_sel)), .cur_fmt(cur_fmt), .pix(pix),
    .line_sol(line_sol), .field_sol(field_sol), .field_id(field_id),
    .h_active(h_active), .v_active(v_active)
  );

  logic [OFS_W-1:0] bofs [NHS];
  logic [OFS_W-1:0] eofs [NHS];
  logic [NHS-1:0]   hs_v;

  assign bofs[0] = hs1_beg_ofs;
  assign eofs[0] = hs1_end_ofs;
  assign bofs[1] = hs2_beg_ofs;
  assign eofs[1] = hs2_end_ofs;

  for (genvar g = 0; g < NHS; g++) begin : g_hs
    vtg_hsync #(.IDX(g), .OFS_W(OFS_W)) u_hs (
      .fmt(cur_fmt), .pix(pix),
      .beg_ofs(bofs[g]), .end_ofs(eofs[g]), .hs(hs_v[g])
    );
  end

  assign hs1 = hs_v[0];
  assign hs2 = hs_v[1];

  always_ff @(posedge clk) begin
    if (!rst_n)     tmg_oe <= !hiz_strap;
    else if (oe_wr) tmg_oe <= oe_wdata;
  end

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_en,
  input logic line_sol,
  input logic field_sol,
  input logic field_id,
  input logic h_active,
  input logic v_active,
  input logic oe_wr,
  input logic oe_wdata,
  input logic tmg_oe
);

  // R9
  sol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_sol |=> !line_sol);

  // R3
  fsol_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_sol |-> line_sol);

  // R3
  fid_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_id) |-> $past(pix_en));

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_active) && $stable(v_active) && $stable(field_id)));

  // R11
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_wr |=> $stable(tmg_oe));

  // R11
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_wr |=> (tmg_oe == $past(oe_wdata)));

endmodule

bind video_timing_gen vtg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
  .line_sol(line_sol), .field_sol(field_sol), .field_id(field_id),
  .h_active(h_active), .v_active(v_active),
  .oe_wr(oe_wr), .oe_wdata(oe_wdata), .tmg_oe(tmg_oe)
);

// File: tb/tb_video_timing_gen.sv
module tb_video_timing_gen;

  logic       clk = 1'b0;
  logic       rst_n, pix_en, oe_wr, oe_wdata, hiz_strap;
  logic [1:0] fmt_sel;
  logic [9:0] hs1_beg_ofs, hs1_end_ofs, hs2_beg_ofs, hs2_end_ofs;
  logic       hs1, hs2, line_sol, field_sol, field_id, h_active, v_active, tmg_oe;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  video_timing_gen #(
    .F60_LINES(21), .F50_LINES(25), .VACT60(16), .VACT50(20),
    .VBL60(2), .VBL50(2), .OFS_W(10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .fmt_sel(fmt_sel),
    .hs1_beg_ofs(hs1_beg_ofs), .hs1_end_ofs(hs1_end_ofs),
    .hs2_beg_ofs(hs2_beg_ofs), .hs2_end_ofs(hs2_end_ofs),
    .oe_wr(oe_wr), .oe_wdata(oe_wdata), .hiz_strap(hiz_strap),
    .hs1(hs1), .hs2(hs2), .line_sol(line_sol), .field_sol(field_sol),
    .field_id(field_id), .h_active(h_active), .v_active(v_active),
    .tmg_oe(tmg_oe)
  );

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic measure_line(output int len, output int hact,
                              output int r1, output int f1,
                              output int r2, output int f2);
    logic [1023:0] s1, s2;
    int k;
    s1 = '0; s2 = '0; hact = 0;
    r1 = -1; f1 = -1; r2 = -1; f2 = -1;
    while (!line_sol) @(negedge clk);
    k = 0;
    do begin
      s1[k] = hs1;
      s2[k] = hs2;
      if (h_active) hact++;
      @(negedge clk);
      k++;
    end while (!line_sol && k < 1024);
    len = k;
    for (int i = 0; i < len; i++) begin
      int p;
      p = (i == 0) ? len - 1 : i - 1;
      if (s1[i] && !s1[p]) r1 = i;
      if (!s1[i] && s1[p]) f1 = i;
      if (s2[i] && !s2[p]) r2 = i;
      if (!s2[i] && s2[p]) f2 = i;
    end
  endtask

  task automatic wait_frame_start();
    @(negedge clk);
    while (!(field_sol && !field_id)) @(negedge clk);
  endtask

  // starts at a frame-start sample, ends at the next one
  task automatic measure_frame(output int n0, output int n1,
                               output int va, output int fid_bad);
    int  fld;
    bit  done;
    fld = 0; n0 = 0; n1 = 0; va = 0; fid_bad = 0; done = 0;
    while (!done) begin
      if (line_sol) begin
        if (field_sol && (n0 + n1) > 0) begin
          if (fld == 1) done = 1;
          else fld = 1;
        end
        if (!done) begin
          if (int'(field_id) != fld) fid_bad++;
          if (fld == 0) n0++; else n1++;
          if (v_active) va++;
        end
      end
      if (!done) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pix_en = 1'b1; fmt_sel = 2'd0; oe_wr = 1'b0; oe_wdata = 1'b0;
    hiz_strap = 1'b1;
    hs1_beg_ofs = '0; hs1_end_ofs = '0; hs2_beg_ofs = '0; hs2_end_ofs = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 line_sol at first pixel after reset", int'(line_sol), 1);
    chk("R3 field_sol at first line after reset", int'(field_sol), 1);
    chk("R3 field_id after reset", int'(field_id), 0);
    chk("R11 tmg_oe from strap", int'(tmg_oe), 0);
  endtask

  task automatic t_defaults();
    int len, ha, r1, f1, r2, f2;
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R1 line length fmt0", len, 858);
    chk("R2 active pixels fmt0", ha, 720);
    chk("R5 hs1 default begin", r1, 0);
    chk("R5 hs1 default end", f1, 64);
    chk("R5 hs2 default begin", r2, 32);
    chk("R5 hs2 default end", f2, 96);
  endtask

  task automatic t_offsets();
    int len, ha, r1, f1, r2, f2;
    hs1_beg_ofs = 10'd100; hs1_end_ofs = 10'd100;
    hs2_beg_ofs = 10'd800; hs2_end_ofs = 10'd900;
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R7 hs1 begin with own offset", r1, 100);
    chk("R7 hs1 end with own offset", f1, 164);
    chk("R6 hs2 wrapped begin", r2, 832);
    chk("R6 hs2 wrapped end", f2, 138);
    hs1_beg_ofs = 10'd0; hs1_end_ofs = 10'd0;
    hs2_beg_ofs = 10'd850; hs2_end_ofs = 10'd0;
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R5 hs2 begin modulo line length", r2, 24);
    chk("R5 hs2 end", f2, 96);
    chk("R7 hs1 unaffected by hs2 offsets", f1, 64);
    hs2_beg_ofs = 10'd0;
  endtask

  task automatic t_freeze();
    logic h1v, hav;
    int   len, ha, r1, f1, r2, f2;
    @(negedge clk);
    while (!line_sol) @(negedge clk);
    h1v = hs1; hav = h_active;
    pix_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 line_sol low while stalled", int'(line_sol), 0);
      chk("R10 hs1 held while stalled", int'(hs1), int'(h1v));
      chk("R10 h_active held while stalled", int'(h_active), int'(hav));
    end
    pix_en = 1'b1;
    #1;
    chk("R9 line_sol on resume at pixel 0", int'(line_sol), 1);
    @(negedge clk);
    chk("R9 line_sol single cycle", int'(line_sol), 0);
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R10 next line length after stall", len, 858);
  endtask

  task automatic t_oe();
    hiz_strap = 1'b0;
    @(negedge clk);
    chk("R11 strap ignored after reset", int'(tmg_oe), 0);
    oe_wr = 1'b1; oe_wdata = 1'b1;
    @(negedge clk);
    oe_wr = 1'b0; oe_wdata = 1'b0;
    chk("R11 write enables pins", int'(tmg_oe), 1);
    @(negedge clk);
    chk("R11 no write holds flag", int'(tmg_oe), 1);
    oe_wr = 1'b1;
    @(negedge clk);
    oe_wr = 1'b0;
    chk("R11 write disables pins", int'(tmg_oe), 0);
  endtask

  task automatic t_frame(string tag, int e0, int e1, int eva);
    int n0, n1, va, fb;
    measure_frame(n0, n1, va, fb);
    chk({"R3 field0 lines ", tag}, n0, e0);
    chk({"R3 field1 lines ", tag}, n1, e1);
    chk({"R3 field_id per field ", tag}, fb, 0);
    chk({"R4 active lines ", tag}, va, eva);
  endtask

  task automatic t_formats();
    int len, ha, r1, f1, r2, f2;
    wait_frame_start();
    t_frame("60Hz", 11, 10, 16);
    measure_line(len, ha, r1, f1, r2, f2);
    fmt_sel = 2'd1;
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R8 old length kept mid-frame", len, 858);
    wait_frame_start();
    t_frame("50Hz", 13, 12, 20);
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R1 line length fmt1", len, 864);
    chk("R2 active pixels fmt1", ha, 720);
    fmt_sel = 2'd2;
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R8 fmt1 kept until frame end", len, 864);
    wait_frame_start();
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R1 line length fmt2", len, 780);
    chk("R2 active pixels fmt2", ha, 640);
    chk("R5 hs1 square default end", f1, 58);
    chk("R5 hs2 square default end", f2, 90);
    fmt_sel = 2'd3;
    wait_frame_start();
    measure_line(len, ha, r1, f1, r2, f2);
    chk("R1 line length fmt3", len, 944);
    chk("R2 active pixels fmt3", ha, 768);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_defaults();
    t_offsets();
    t_freeze();
    t_oe();
    t_formats();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule